// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer whose write port and read port run on two unrelated clocks, so a producer and a consumer can move data at the same time. Words are 9 bits wide and the storage depth is a power of two set by a parameter. The write side reports full (or input-ready), half-full and almost-full. The read side reports empty (or output-ready) and almost-empty. The almost-empty and almost-full thresholds are held in an offset register. That register can be loaded from the data inputs or shifted in one bit per write clock.

Read timing is chosen at master reset by the shared mode/serial-data pin. In standard timing, each word has to be requested and appears one read clock later. In fall-through timing, the oldest word is presented on the output by itself and a read request consumes it.

A partial reset empties the buffer but keeps the offsets and the timing mode. A retransmit input rewinds the read side to the first stored location so the same data can be read again. An output-enable input gates the data outputs and drives a separate drive-enable pin for an external tri-state pad.

Top module: `dcfifo_pflag`

## Requirements
- R1: Words leave in the order they were accepted, with the two clocks at unrelated frequencies. Each pointer crosses clock domains as a Gray code that changes by at most one bit per clock, except on the read cycle right after a retransmit.
- R2: In standard timing (mode_si low during master reset), rflag is the empty flag (1 = empty) and wflag is the full flag (1 = full). A word is presented on dout at the first rclk edge where ren is high and rflag is low. At every other edge, dout holds its value.
- R3: In fall-through timing (mode_si high during master reset), rflag means output-ready and wflag means input-ready. The oldest word appears on dout with no read request. A read request taken while rflag is high consumes that word. The buffer holds DEPTH words in storage plus one on the output.
- R4: A write taken while the buffer is full is dropped. A read request taken while it is empty leaves the data, the output and the pointers unchanged.
- R5: Counting words in storage on the write side: half_full is high when the count exceeds DEPTH/2, almost_full is high when the count is at least DEPTH minus the almost-full offset, and full is reached at DEPTH.
- R6: almost_empty is high when the stored level is at most the almost-empty offset. In fall-through timing, that level includes the word held on the output.
- R7: Master reset (mrst_n low) empties the buffer, sets dout to 0, sets both offsets to their default parameters (7 and 7 by default) and captures the timing mode from mode_si.
- R8: While ld is high, successive wclk edges load din[AW-1:0] first into the almost-empty offset, then into the almost-full offset, alternating. A fresh ld pulse starts again at the almost-empty offset. Writes are suppressed while ld or sen is high.
- R9: While sen is high, each wclk edge shifts mode_si into the offset register. After 2*AW edges, the first bit shifted has reached bit 0 of the almost-empty offset and the last bit shifted has reached the top bit of the almost-full offset. In other words, the almost-empty offset goes in LSB first, followed by the almost-full offset LSB first.
- R10: Partial reset (prst_n low) empties the buffer and clears dout but keeps both offsets and the timing mode.
- R11: A pulse on rt returns the read pointer to location 0, so every word written since the last reset is read again in order. This is valid when no more than DEPTH words have been written since that reset and writes are idle.
- R12: While oe is low, dout is 0 and dout_drv is 0. The word held inside the block is kept and reappears when oe returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low, sampled on both clocks |
| prst_n | input | 1 | Partial reset, active low, sampled on both clocks |
| wen | input | 1 | Write request |
| din | input | DW | Write data; its low AW bits also carry parallel offset loads |
| ld | input | 1 | Parallel offset load |
| sen | input | 1 | Serial offset shift enable |
| mode_si | input | 1 | Timing mode at master reset; serial offset data otherwise |
| ren | input | 1 | Read request |
| rt | input | 1 | Retransmit |
| oe | input | 1 | Output enable |
| dout | output | DW | Read data, 0 while oe is low |
| dout_drv | output | 1 | Drive enable for an external tri-state pad |
| wflag | output | 1 | Full (standard) or input-ready (fall-through) |
| rflag | output | 1 | Empty (standard) or output-ready (fall-through) |
| half_full | output | 1 | More than half the storage occupied |
| almost_empty | output | 1 | Level at or below the almost-empty offset |
| almost_full | output | 1 | Level at or above DEPTH minus the almost-full offset |

## Verification
The assertions assume that each reset is held for at least two edges of both clocks. They also assume that retransmit is pulsed only while writes are idle, since the Gray-step check on the read pointer excuses only the cycle after rt. The bench holds every reset for four read clocks, pulses rt with wen low, and loads offsets only while the buffer is idle. The comparison against the reference queue therefore never runs into a pointer that is jumping or a threshold that is changing.

// File: rtl/dcfifo_pflag.sv
`timescale 1ns/1ps
module dcfifo_pflag #(
  parameter int DW     = 9,
  parameter int AW     = 6,
  parameter int DEF_AE = 7,
  parameter int DEF_AF = 7
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          wen,
  input  logic [DW-1:0] din,
  input  logic          ld,
  input  logic          sen,
  input  logic          mode_si,
  input  logic          ren,
  input  logic          rt,
  input  logic          oe,
  output logic [DW-1:0] dout,
  output logic          dout_drv,
  output logic          wflag,
  output logic          rflag,
  output logic          half_full,
  output logic          almost_empty,
  output logic          almost_full
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2);

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic          rst;
  logic [DW-1:0] mem [DEPTH];

  // write domain
  logic          fwft_w, ld_sel;
  logic [AW-1:0] ae_off, af_off;
  logic [PW-1:0] wbin, wgray, rg_s1, rg_s2, wcount;
  logic          full, wr_ok;

  // read domain
  logic          fwft_r, ov;
  logic [PW-1:0] rbin, rgray, wg_s1, wg_s2, rcount, rlevel;
  logic [DW-1:0] dq;
  logic          rempty, rd_std, ld_head, pop;

  assign rst    = !mrst_n || !prst_n;
  assign wcount = wbin - g2b(rg_s2);
  assign full   = (wcount == DEPTH_P);
  assign wr_ok  = wen && !full && !ld && !sen;

  always_ff @(posedge wclk) begin
    if (rst) begin
      wbin  <= '0;
      wgray <= '0;
      rg_s1 <= '0;
      rg_s2 <= '0;
    end else begin
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      if (wr_ok) begin
        wbin  <= wbin + 1'b1;
        wgray <= b2g(wbin + 1'b1);
      end
    end
  end

  always_ff @(posedge wclk) begin
    if (!rst && wr_ok) mem[wbin[AW-1:0]] <= din;
  end

  always_ff @(posedge wclk) begin
    if (!mrst_n) begin
      fwft_w <= mode_si;
      ae_off <= AW'(DEF_AE);
      af_off <= AW'(DEF_AF);
      ld_sel <= 1'b0;
    end else if (!prst_n) begin
      ld_sel <= 1'b0;
    end else if (ld) begin
      ld_sel <= ~ld_sel;
      if (!ld_sel) ae_off <= din[AW-1:0];
      else         af_off <= din[AW-1:0];
    end else begin
      ld_sel <= 1'b0;
      if (sen) {af_off, ae_off} <= {mode_si, af_off, ae_off[AW-1:1]};
    end
  end

  assign half_full   = wcount > HALF_P;
  assign almost_full = wcount >= (DEPTH_P - {1'b0, af_off});
  assign wflag       = fwft_w ? !full : full;

  assign rcount  = g2b(wg_s2) - rbin;
  assign rempty  = (rcount == '0);
  assign rd_std  = !fwft_r && ren && !rempty;
  assign ld_head = fwft_r && !rempty && (!ov || ren);
  assign pop     = rd_std || ld_head;
  assign rlevel  = rcount + {{AW{1'b0}}, fwft_r && ov};

  always_ff @(posedge rclk) begin
    if (!mrst_n) fwft_r <= mode_si;
  end

  always_ff @(posedge rclk) begin
    if (rst) begin
      rbin  <= '0;
      rgray <= '0;
      wg_s1 <= '0;
      wg_s2 <= '0;
      ov    <= 1'b0;
      dq    <= '0;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      if (rt) begin
        rbin  <= '0;
        rgray <= '0;
        ov    <= 1'b0;
      end else if (pop) begin
        rbin  <= rbin + 1'b1;
        rgray <= b2g(rbin + 1'b1);
        dq    <= mem[rbin[AW-1:0]];
        if (fwft_r) ov <= 1'b1;
      end else if (fwft_r && ren) begin
        ov <= 1'b0;
      end
    end
  end

  assign almost_empty = rlevel <= {1'b0, ae_off};
  assign rflag        = fwft_r ? ov : rempty;
  assign dout         = oe ? dq : '0;
  assign dout_drv     = oe;
endmodule

// File: rtl/dcfifo_pflag_chk.sv
`timescale 1ns/1ps
module dcfifo_pflag_chk #(
  parameter int PW = 7,
  parameter int DW = 9
) (
  input logic          wclk,
  input logic          rclk,
  input logic          mrst_n,
  input logic          prst_n,
  input logic          wen,
  input logic          ren,
  input logic          rt,
  input logic          full,
  input logic          rempty,
  input logic          fwft_r,
  input logic          ov,
  input logic          half_full,
  input logic          almost_full,
  input logic [PW-1:0] wbin,
  input logic [PW-1:0] wgray,
  input logic [PW-1:0] rbin,
  input logic [PW-1:0] rgray,
  input logic [DW-1:0] dq
);
  logic rst;
  assign rst = !mrst_n || !prst_n;

  assert_wgray_step_R1: assert property (@(posedge wclk) disable iff (rst)
    $countones(wgray ^ $past(wgray)) <= 1);

  assert_rgray_step_R1: assert property (@(posedge rclk) disable iff (rst)
    !$past(rt) |-> $countones(rgray ^ $past(rgray)) <= 1);

  assert_std_hold_R2: assert property (@(posedge rclk) disable iff (rst)
    (!fwft_r && !(ren && !rempty)) |=> $stable(dq));

  assert_fwft_hold_R3: assert property (@(posedge rclk) disable iff (rst)
    (fwft_r && ov && !ren && !rt) |=> (ov && $stable(dq)));

  assert_no_overflow_R4: assert property (@(posedge wclk) disable iff (rst)
    (full && wen) |=> $stable(wbin));

  assert_no_underflow_R4: assert property (@(posedge rclk) disable iff (rst)
    (rempty && !rt) |=> $stable(rbin));

  assert_full_levels_R5: assert property (@(posedge wclk) disable iff (rst)
    full |-> (half_full && almost_full));
endmodule

bind dcfifo_pflag dcfifo_pflag_chk #(.PW(AW + 1), .DW(DW)) u_chk (
  .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
  .wen(wen), .ren(ren), .rt(rt), .full(full), .rempty(rempty),
  .fwft_r(fwft_r), .ov(ov), .half_full(half_full), .almost_full(almost_full),
  .wbin(wbin), .wgray(wgray), .rbin(rbin), .rgray(rgray), .dq(dq)
);

// File: tb/dcfifo_pflag_tb_top.sv
`timescale 1ns/1ps
module dcfifo_pflag_tb_top;
  localparam int DW = 9;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic wclk = 1'b0, rclk = 1'b0;
  always #2.5 wclk = ~wclk;
  always #3.65 rclk = ~rclk;

  logic mrst_n = 1'b0, prst_n = 1'b1, wen = 1'b0, ld = 1'b0, sen = 1'b0;
  logic mode_si = 1'b0, ren = 1'b0, rt = 1'b0, oe = 1'b1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_drv, wflag, rflag, half_full, almost_empty, almost_full;

  dcfifo_pflag #(.DW(DW), .AW(AW)) dut_i (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n), .wen(wen),
    .din(din), .ld(ld), .sen(sen), .mode_si(mode_si), .ren(ren), .rt(rt),
    .oe(oe), .dout(dout), .dout_drv(dout_drv), .wflag(wflag), .rflag(rflag),
    .half_full(half_full), .almost_empty(almost_empty), .almost_full(almost_full)
  );

  int checks = 0, fails = 0;
  bit fwft = 1'b0, mon_on = 1'b0, done = 1'b0;
  logic [DW-1:0] model[$], hist[$];
  logic [DW-1:0] last = '0, nv = 9'd5;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int head();
    return (model.size() > 0) ? int'(model[0]) : -1;
  endfunction

  function automatic bit is_full();
    return fwft ? !wflag : wflag;
  endfunction

  task automatic wr(input logic [DW-1:0] v, output bit took);
    @(negedge wclk);
    took = !is_full();
    din = v;
    wen = 1'b1;
    if (took) begin
      model.push_back(v);
      hist.push_back(v);
    end
    @(negedge wclk);
    wen = 1'b0;
  endtask

  task automatic wr_n(input int n);
    repeat (n) begin
      bit t;
      wr(nv, t);
      nv = nv + 9'd37;
    end
  endtask

  task automatic rd(output bit got);
    logic [DW-1:0] e;
    @(negedge rclk);
    got = fwft ? rflag : !rflag;
    if (fwft && got)
      chk(model.size() > 0 && dout == model[0], "R3 fall-through word", int'(dout), head());
    ren = 1'b1;
    @(posedge rclk);
    #1;
    if (got) begin
      if (model.size() == 0) chk(1'b0, "R1 read with nothing stored", 1, 0);
      else begin
        e = model.pop_front();
        if (!fwft) begin
          chk(dout == e, "R2 data order", int'(dout), int'(e));
          last = e;
        end
      end
    end else if (!fwft) begin
      chk(dout == last, "R4 read while empty ignored", int'(dout), int'(last));
    end
    @(negedge rclk);
    ren = 1'b0;
  endtask

  task automatic drain(input int keep);
    int g = 0;
    while (model.size() > keep && g < 4000) begin
      bit got;
      rd(got);
      g++;
    end
  endtask

  task automatic settle();
    repeat (8) @(posedge rclk);
    @(negedge wclk);
  endtask

  task automatic mreset(input bit m);
    mon_on = 1'b0;
    @(negedge wclk);
    mrst_n = 1'b0; mode_si = m;
    wen = 0; ld = 0; sen = 0; ren = 0; rt = 0;
    repeat (4) @(posedge rclk);
    @(negedge wclk);
    mrst_n = 1'b1;
    settle();
    mode_si = 1'b0;
    fwft = m;
    model.delete(); hist.delete(); last = '0;
    mon_on = 1'b1;
  endtask

  task automatic preset();
    mon_on = 1'b0;
    @(negedge wclk);
    prst_n = 1'b0;
    repeat (4) @(posedge rclk);
    @(negedge wclk);
    prst_n = 1'b1;
    settle();
    model.delete(); hist.delete(); last = '0;
    mon_on = 1'b1;
  endtask

  task automatic stream(input int n);
    fork
      begin
        for (int i = 0; i < n; i++) begin
          bit t = 1'b0;
          while (!t) wr(nv, t);
          nv = nv + 9'd37;
          if (i % 3 == 0) @(negedge wclk);
        end
      end
      begin
        int gotn = 0, g = 0;
        while (gotn < n && g < 20000) begin
          bit got;
          rd(got);
          if (got) gotn++;
          g++;
          if (g % 5 == 0) @(negedge rclk);
        end
      end
    join
    settle();
    chk(model.size() == 0, "R1 stream fully delivered", model.size(), 0);
  endtask

  // reference comparison on every read clock
  always @(posedge rclk) begin
    #2;
    if (mon_on && oe) begin
      if (fwft) begin
        if (rflag) chk(model.size() > 0 && dout == model[0], "R1 head matches queue", int'(dout), head());
      end else begin
        chk(dout == last && (rflag || model.size() > 0), "R2 output/empty vs queue", int'(dout), int'(last));
      end
    end
  end

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #500000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      finish_up();
    end
  end

  initial begin
    bit t;
    // standard timing
    mreset(1'b0);
    chk(rflag == 1'b1, "R7 empty after reset", rflag, 1);
    chk(wflag == 1'b0, "R7 not full after reset", wflag, 0);
    chk(almost_empty == 1'b1 && almost_full == 1'b0 && half_full == 1'b0, "R7 level flags", almost_empty, 1);
    chk(dout == '0 && dout_drv == 1'b1, "R7 dout cleared", int'(dout), 0);

    wr_n(7); settle();
    chk(almost_empty == 1'b1, "R6 default offset, 7 words", almost_empty, 1);
    wr_n(1); settle();
    chk(almost_empty == 1'b0, "R6 default offset, 8 words", almost_empty, 0);
    drain(0); settle();
    chk(rflag == 1'b1, "R2 empty after drain", rflag, 1);
    begin bit g; rd(g); end

    wr_n(DEPTH); settle();
    chk(wflag == 1'b1, "R5 full at DEPTH", wflag, 1);
    chk(half_full && almost_full, "R5 half and almost full at DEPTH", {half_full, almost_full}, 3);
    wr(9'h1AA, t);
    drain(57); settle();
    chk(wflag == 1'b0 && almost_full == 1'b1, "R5 almost full at 57", almost_full, 1);
    drain(56); settle();
    chk(almost_full == 1'b0, "R5 almost full off at 56", almost_full, 0);
    drain(33); settle();
    chk(half_full == 1'b1, "R5 half full at 33", half_full, 1);
    drain(32); settle();
    chk(half_full == 1'b0, "R5 half full off at 32", half_full, 0);
    drain(0); settle();
    chk(rflag == 1'b1, "R4 write while full dropped", rflag, 1);

    stream(150);

    // parallel offset load: ae=3, af=10
    @(negedge wclk); ld = 1'b1; din = 9'd3;
    @(negedge wclk); din = 9'd10; wen = 1'b1;
    @(negedge wclk); ld = 1'b0; wen = 1'b0;
    settle();
    chk(rflag == 1'b1, "R8 write suppressed during load", rflag, 1);
    wr_n(3); settle();
    chk(almost_empty == 1'b1, "R8 ae offset 3, 3 words", almost_empty, 1);
    wr_n(1); settle();
    chk(almost_empty == 1'b0, "R8 ae offset 3, 4 words", almost_empty, 0);
    wr_n(49); settle();
    chk(almost_full == 1'b0, "R8 af offset 10, 53 words", almost_full, 0);
    wr_n(1); settle();
    chk(almost_full == 1'b1, "R8 af offset 10, 54 words", almost_full, 1);
    drain(0); settle();

    // serial offset load: ae=5, af=12
    for (int i = 0; i < 2 * AW; i++) begin
      logic [AW-1:0] a = AW'(5), f = AW'(12);
      @(negedge wclk);
      sen = 1'b1;
      mode_si = (i < AW) ? a[i] : f[i-AW];
    end
    @(negedge wclk); sen = 1'b0; mode_si = 1'b0;
    wr_n(5); settle();
    chk(almost_empty == 1'b1, "R9 ae offset 5, 5 words", almost_empty, 1);
    wr_n(1); settle();
    chk(almost_empty == 1'b0, "R9 ae offset 5, 6 words", almost_empty, 0);
    wr_n(45); settle();
    chk(almost_full == 1'b0, "R9 af offset 12, 51 words", almost_full, 0);
    wr_n(1); settle();
    chk(almost_full == 1'b1, "R9 af offset 12, 52 words", almost_full, 1);
    drain(10);

    // partial reset keeps offsets and mode
    preset();
    chk(rflag == 1'b1 && almost_empty == 1'b1, "R10 empty after partial reset", rflag, 1);
    chk(dout == '0, "R10 dout cleared", int'(dout), 0);
    wr_n(6); settle();
    chk(almost_empty == 1'b0, "R10 offset 5 kept", almost_empty, 0);
    chk(dout == '0, "R10 standard timing kept", int'(dout), 0);
    drain(0); settle();

    // retransmit
    mreset(1'b0);
    wr_n(6); settle();
    drain(2);
    @(negedge rclk); rt = 1'b1;
    @(posedge rclk); #1 model = hist;
    @(negedge rclk); rt = 1'b0;
    settle();
    chk(rflag == 1'b0 && model.size() == 6, "R11 rewound level", model.size(), 6);
    drain(0); settle();
    chk(rflag == 1'b1, "R11 replay complete", rflag, 1);

    // fall-through timing
    mreset(1'b1);
    chk(rflag == 1'b0 && wflag == 1'b1, "R3 not ready, input ready", {rflag, wflag}, 1);
    wr_n(1); settle();
    chk(rflag == 1'b1 && dout == model[0], "R3 first word falls through", int'(dout), head());
    wr_n(6); settle();
    chk(almost_empty == 1'b1, "R6 fall-through level 7", almost_empty, 1);
    wr_n(1); settle();
    chk(almost_empty == 1'b0, "R6 fall-through level 8 counts output word", almost_empty, 0);
    drain(0); settle();
    chk(rflag == 1'b0, "R3 not ready after drain", rflag, 0);
    stream(150);

    for (int i = 0; i < DEPTH + 2; i++) begin
      wr(nv, t);
      nv = nv + 9'd37;
    end
    settle();
    chk(model.size() == DEPTH + 1, "R3 capacity DEPTH+1", model.size(), DEPTH + 1);
    chk(wflag == 1'b0, "R3 input not ready when full", wflag, 0);
    drain(0); settle();

    preset();
    wr_n(1); settle();
    chk(rflag == 1'b1 && dout == model[0], "R10 fall-through kept", int'(dout), head());

    // output enable
    @(negedge rclk); oe = 1'b0;
    @(negedge rclk);
    chk(dout == '0 && dout_drv == 1'b0, "R12 outputs off", int'(dout), 0);
    oe = 1'b1;
    @(negedge rclk);
    chk(dout == model[0] && dout_drv == 1'b1, "R12 word restored", int'(dout), head());
    drain(0); settle();

    done = 1'b1;
    finish_up();
  end
endmodule